// File: doc/BRIEF.md
# Serial Flash Streaming Read Sequencer

This block is the master side of an SPI link to a serial flash device. It turns a small set of commands into framed bus transactions. An open command lowers chip select and sends the read opcode with a 24-bit start address. Each next-byte command then clocks one more byte out of the device and delivers it on a byte stream. A close command releases chip select. Two single-shot commands fetch the device status byte and the 16-bit identifier. A checked read fetches a payload of N bytes, then a four-byte trailer. It compares the trailer with a CRC-32 that it computes over the payload and reports pass or fail.

Commands enter through a valid/ready port. The command port is ready only when no transaction is in progress, which means idle or an open stream waiting for its next command. Bytes leave through a valid/ready stream. A byte that has been presented is held, with its data unchanged, until the consumer accepts it. No further bus activity starts while a byte waits. The serial clock comes from the system clock through a fixed divider and follows SPI mode 0.

Top module: `sflash_stream_rd`

## Requirements
- R1: While reset is held and on its release, cs_n is 1, sclk is 0, cmd_ready is 1, dout_valid is 0, op_done is 0 and err is 0.
- R2: Command codes on cmd_op are 1 open, 2 next-byte, 3 close, 4 status, 5 identifier and 6 checked read. A command is taken when cmd_valid and cmd_ready are both 1. cmd_ready is 1 only in idle or in an open stream waiting for a command.
- R3: Open lowers cs_n and sends byte 0x03, then the three bytes of cmd_addr, most significant first. Each byte is sent MSB first in mode 0: sclk idles low, mosi is stable at every rising sclk edge, and miso is sampled on the rising edge.
- R4: Each next-byte command in an open stream returns the byte at the following address, starting at the open address and stepping by one, on dout_data.
- R5: Once dout_valid is 1, it stays 1 and dout_data stays unchanged until a cycle with dout_ready high. cmd_ready is 0 while dout_valid is 1.
- R6: Close raises cs_n, returns to idle and pulses op_done. cs_n never rises while sclk is high, and sclk never pulses while cs_n is high.
- R7: Status sends 0x05 and one 0x00 dummy byte, then captures the third byte into status_q and releases cs_n.
- R8: Identifier sends 0x90 and three 0x00 bytes, then captures two bytes into id_q as {first, second}. A device answering 0xBF then 0x41 gives 0xBF41.
- R9: A checked read with length L, a multiple of 4 and possibly 0, sends 0x03 and the address, and delivers the L payload bytes on the byte stream. It then reads four trailer bytes and assembles them least significant byte first.
- R10: chk_pass is 1 after a checked read only when the trailer equals the CRC of the payload. The CRC is MSB-first, non-reflected CRC-32 with polynomial 0x04C11DB7, initial value 0xFFFFFFFF and no final inversion, restarted for every checked read.
- R11: An illegal command sets err, which stays 1 until reset, and causes no bus activity or state change. Illegal commands are: next-byte or close in idle; open, status, identifier or checked read in an open stream; a checked-read length that is not a multiple of 4; and codes 0 and 7.
- R12: op_done is a one-cycle pulse at the end of open, close, status, identifier and checked read. status_q, id_q and chk_pass are valid from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 24 | Start address for open and checked read |
| cmd_len | input | 16 | Payload length of a checked read |
| dout_valid | output | 1 | Stream byte present |
| dout_ready | input | 1 | Consumer accepts the stream byte |
| dout_data | output | 8 | Stream byte |
| op_done | output | 1 | Command completion pulse |
| status_q | output | 8 | Last status byte read |
| id_q | output | 16 | Last identifier read |
| chk_pass | output | 1 | Result of the last checked read |
| err | output | 1 | Sticky illegal-command flag |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
Every bus byte takes 16 times HALF_DIV system cycles, plus one launch cycle. The number of cycles until dout_valid rises or op_done pulses therefore depends on the byte count of the frame. For that reason the bench never samples after a fixed delay. It waits, on falling clock edges, for dout_valid or the one-cycle op_done, and reads status_q, id_q and chk_pass in that same cycle. A close takes effect on the clock edge that accepts it, so its op_done and the raised cs_n are checked at the first falling edge after the handshake. Results of illegal commands are checked at the next falling edge: err must be 1, and the device model must have seen no new chip-select fall.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_OPEN    = 3'd1,
    OP_NEXT    = 3'd2,
    OP_CLOSE   = 3'd3,
    OP_STATUS  = 3'd4,
    OP_IDENT   = 3'd5,
    OP_CHECKED = 3'd6,
    OP_RSVD    = 3'd7
  } cmd_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR,
    S_STREAM,
    S_DATA,
    S_OUT
  } seq_state_e;

  typedef enum logic [1:0] {
    K_STREAM,
    K_STATUS,
    K_IDENT,
    K_CHECK
  } xfer_kind_e;

  localparam logic [7:0]  FL_OPC_READ   = 8'h03;
  localparam logic [7:0]  FL_OPC_STATUS = 8'h05;
  localparam logic [7:0]  FL_OPC_IDENT  = 8'h90;
  localparam logic [31:0] CRC_POLY      = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_INIT      = 32'hFFFF_FFFF;

endpackage

// File: rtl/sfr_byte_shift.sv
module sfr_byte_shift #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic          active;
  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    sh_tx;
  logic [7:0]    sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      div_cnt <= '0;
      bit_idx <= '0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      sclk    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          div_cnt <= '0;
          bit_idx <= '0;
          sh_tx   <= tx_byte;
          sclk    <= 1'b0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          sh_rx <= {sh_rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_idx == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 3'd1;
            sh_tx   <= {sh_tx[6:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + DW'(1);
      end
    end
  end

  assign mosi    = active & sh_tx[7];
  assign rx_byte = sh_rx;

endmodule

// File: rtl/sfr_crc32.sv
module sfr_crc32 #(
  parameter logic [31:0] POLY = 32'h04C1_1DB7,
  parameter logic [31:0] INIT = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  logic [31:0] nxt;

  always_comb begin
    logic fb;
    nxt = crc;
    for (int i = 7; i >= 0; i--) begin
      fb  = nxt[31] ^ din[i];
      nxt = {nxt[30:0], 1'b0};
      if (fb) nxt = nxt ^ POLY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= INIT;
    else if (clr) crc <= INIT;
    else if (en)  crc <= nxt;
  end

endmodule

// File: rtl/sflash_stream_rd.sv
module sflash_stream_rd
  import sfr_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 24,
  parameter int LEN_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [7:0]        dout_data,
  output logic              op_done,
  output logic [7:0]        status_q,
  output logic [15:0]       id_q,
  output logic              chk_pass,
  output logic              err,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam logic [2:0] ADDR_LAST = 3'(ADDR_BYTES);

  seq_state_e        state;
  xfer_kind_e        kind;
  logic [2:0]        idx;
  logic [1:0]        tcnt;
  logic [LEN_W-1:0]  remain;
  logic [ADDR_W-1:0] addr_q;
  logic [23:0]       stored;
  logic              launch;

  logic       sh_done;
  logic [7:0] sh_rx;
  logic [7:0] tx_byte;
  logic [7:0] hdr_byte;
  logic [2:0] hdr_last;
  logic       cmd_fire;
  logic       legal;
  logic       crc_clr;
  logic       crc_en;
  logic [31:0] crc_val;
  cmd_op_e    op;

  assign op        = cmd_op_e'(cmd_op);
  assign cmd_ready = (state == S_IDLE) || (state == S_STREAM);
  assign cmd_fire  = cmd_valid && cmd_ready;

  always_comb begin
    legal = 1'b0;
    if (state == S_IDLE) begin
      unique case (op)
        OP_OPEN, OP_STATUS, OP_IDENT: legal = 1'b1;
        OP_CHECKED:                   legal = (cmd_len[1:0] == 2'b00);
        default:                      legal = 1'b0;
      endcase
    end else if (state == S_STREAM) begin
      legal = (op == OP_NEXT) || (op == OP_CLOSE);
    end
  end

  always_comb begin
    hdr_last = (kind == K_STATUS) ? 3'd1 : ADDR_LAST;
    hdr_byte = 8'h00;
    if (idx == 3'd0) begin
      unique case (kind)
        K_STATUS: hdr_byte = FL_OPC_STATUS;
        K_IDENT:  hdr_byte = FL_OPC_IDENT;
        default:  hdr_byte = FL_OPC_READ;
      endcase
    end else if ((kind == K_STREAM) || (kind == K_CHECK)) begin
      hdr_byte = 8'(addr_q >> (8 * (ADDR_BYTES - int'(idx))));
    end
  end

  assign tx_byte = (state == S_HDR) ? hdr_byte : 8'h00;
  assign crc_clr = cmd_fire && legal && (op == OP_CHECKED);
  assign crc_en  = (state == S_DATA) && sh_done && (kind == K_CHECK) && (remain != '0);

  sfr_byte_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (launch),
    .tx_byte (tx_byte),
    .miso    (miso),
    .sclk    (sclk),
    .mosi    (mosi),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

  sfr_crc32 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (sh_rx),
    .crc   (crc_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      kind       <= K_STREAM;
      idx        <= '0;
      tcnt       <= '0;
      remain     <= '0;
      addr_q     <= '0;
      stored     <= '0;
      launch     <= 1'b0;
      cs_n       <= 1'b1;
      op_done    <= 1'b0;
      dout_valid <= 1'b0;
      dout_data  <= '0;
      status_q   <= '0;
      id_q       <= '0;
      chk_pass   <= 1'b0;
      err        <= 1'b0;
    end else begin
      launch  <= 1'b0;
      op_done <= 1'b0;
      if (cmd_fire && !legal) err <= 1'b1;
      unique case (state)
        S_IDLE: begin
          if (cmd_fire && legal) begin
            cs_n   <= 1'b0;
            idx    <= '0;
            tcnt   <= '0;
            launch <= 1'b1;
            addr_q <= cmd_addr;
            remain <= cmd_len;
            state  <= S_HDR;
            unique case (op)
              OP_STATUS:  kind <= K_STATUS;
              OP_IDENT:   kind <= K_IDENT;
              OP_CHECKED: kind <= K_CHECK;
              default:    kind <= K_STREAM;
            endcase
          end
        end
        S_STREAM: begin
          if (cmd_fire && legal) begin
            if (op == OP_NEXT) begin
              launch <= 1'b1;
              state  <= S_DATA;
            end else begin
              cs_n    <= 1'b1;
              op_done <= 1'b1;
              state   <= S_IDLE;
            end
          end
        end
        S_HDR: begin
          if (sh_done) begin
            if (idx == hdr_last) begin
              if (kind == K_STREAM) begin
                op_done <= 1'b1;
                state   <= S_STREAM;
              end else begin
                launch <= 1'b1;
                state  <= S_DATA;
              end
            end else begin
              idx    <= idx + 3'd1;
              launch <= 1'b1;
            end
          end
        end
        S_DATA: begin
          if (sh_done) begin
            unique case (kind)
              K_STREAM: begin
                dout_data  <= sh_rx;
                dout_valid <= 1'b1;
                state      <= S_OUT;
              end
              K_STATUS: begin
                status_q <= sh_rx;
                cs_n     <= 1'b1;
                op_done  <= 1'b1;
                state    <= S_IDLE;
              end
              K_IDENT: begin
                if (tcnt == 2'd0) begin
                  id_q[15:8] <= sh_rx;
                  tcnt       <= 2'd1;
                  launch     <= 1'b1;
                end else begin
                  id_q[7:0] <= sh_rx;
                  cs_n      <= 1'b1;
                  op_done   <= 1'b1;
                  state     <= S_IDLE;
                end
              end
              default: begin
                if (remain != '0) begin
                  remain     <= remain - LEN_W'(1);
                  dout_data  <= sh_rx;
                  dout_valid <= 1'b1;
                  state      <= S_OUT;
                end else begin
                  unique case (tcnt)
                    2'd0: stored[7:0]   <= sh_rx;
                    2'd1: stored[15:8]  <= sh_rx;
                    2'd2: stored[23:16] <= sh_rx;
                    default: ;
                  endcase
                  if (tcnt == 2'd3) begin
                    chk_pass <= (crc_val == {sh_rx, stored});
                    cs_n     <= 1'b1;
                    op_done  <= 1'b1;
                    state    <= S_IDLE;
                  end else begin
                    tcnt   <= tcnt + 2'd1;
                    launch <= 1'b1;
                  end
                end
              end
            endcase
          end
        end
        S_OUT: begin
          if (dout_ready) begin
            dout_valid <= 1'b0;
            if (kind == K_STREAM) begin
              state <= S_STREAM;
            end else begin
              launch <= 1'b1;
              state  <= S_DATA;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sfr_chk.sv
module sfr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       cmd_ready,
  input logic       dout_valid,
  input logic       dout_ready,
  input logic [7:0] dout_data,
  input logic       op_done,
  input logic       err
);
  // R6
  idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R6
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !$past(sclk));

  // R5
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

  // R5
  no_cmd_while_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> !cmd_ready);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

endmodule

bind sflash_stream_rd sfr_chk u_sfr_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .sclk       (sclk),
  .cmd_ready  (cmd_ready),
  .dout_valid (dout_valid),
  .dout_ready (dout_ready),
  .dout_data  (dout_data),
  .op_done    (op_done),
  .err        (err)
);

// File: tb/tb_sflash_stream_rd.sv
module tb_sflash_stream_rd;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [23:0] cmd_addr = '0;
  logic [15:0] cmd_len = '0;
  logic        dout_valid;
  logic        dout_ready = 1'b0;
  logic [7:0]  dout_data;
  logic        op_done;
  logic [7:0]  status_q;
  logic [15:0] id_q;
  logic        chk_pass;
  logic        err;
  logic        sclk, cs_n, mosi;
  logic        miso = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // flash model state
  logic [7:0] fmem [0:1023];
  logic [7:0] m_hdr [0:5];
  logic [7:0] m_in = 8'h00;
  logic [7:0] m_out = 8'h00;
  logic [7:0] m_status = 8'h00;
  logic [15:0] m_id = 16'hBF41;
  int m_bitc = 0;
  int m_bytec = 0;
  int cs_falls = 0;
  int stray = 0;

  sflash_stream_rd dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
    .op_done(op_done), .status_q(status_q), .id_q(id_q), .chk_pass(chk_pass),
    .err(err), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model_next(int nbytes);
    logic [23:0] a;
    a = {m_hdr[1], m_hdr[2], m_hdr[3]};
    if (m_hdr[0] == 8'h03 && nbytes >= 4) return fmem[(a + 24'(nbytes - 4)) & 24'h3FF];
    if (m_hdr[0] == 8'h05 && nbytes >= 2) return m_status;
    if (m_hdr[0] == 8'h90 && nbytes == 4) return m_id[15:8];
    if (m_hdr[0] == 8'h90 && nbytes == 5) return m_id[7:0];
    return 8'h00;
  endfunction

  always @(negedge cs_n) begin
    m_bitc = 0; m_bytec = 0; m_out = 8'h00; miso = 1'b0; cs_falls++;
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      m_in = {m_in[6:0], mosi};
      m_bitc++;
      if (m_bitc == 8) begin
        m_bitc = 0;
        if (m_bytec < 6) m_hdr[m_bytec] = m_in;
        m_bytec++;
        m_out = model_next(m_bytec);
      end
    end else stray++;
  end

  always @(negedge sclk) if (!cs_n) miso = m_out[7 - m_bitc];
  always @(posedge cs_n) if (sclk) stray++;

  function automatic logic [31:0] bench_crc(int a, int n);
    logic [31:0] c;
    logic [7:0] d;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      d = fmem[(a + k) & 1023];
      for (int b = 7; b >= 0; b--) begin
        if (c[31] ^ d[b]) c = {c[30:0], 1'b0} ^ 32'h04C1_1DB7;
        else c = {c[30:0], 1'b0};
      end
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [23:0] a, input logic [15:0] len);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_len = len;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!op_done) @(negedge clk);
  endtask

  task automatic take_byte(input logic [7:0] exp, input int dly, input string req);
    logic [7:0] first;
    while (!dout_valid) @(negedge clk);
    first = dout_data;
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(dout_valid && dout_data == first && !cmd_ready, "R5", "held byte",
          {23'd0, dout_valid, dout_data}, {24'd1, first});
    end
    chk(dout_data == exp, req, "stream byte", dout_data, exp);
    dout_ready = 1'b1;
    @(negedge clk);
    dout_ready = 1'b0;
  endtask

  task automatic check_hdr_read(input logic [23:0] a);
    chk(m_hdr[0] == 8'h03, "R3", "read opcode", m_hdr[0], 8'h03);
    chk({m_hdr[1], m_hdr[2], m_hdr[3]} == a, "R3", "address MSB first",
        {m_hdr[1], m_hdr[2], m_hdr[3]}, a);
  endtask

  task automatic run_stream(input int a, input int n, input int dmax);
    do_cmd(3'd1, 24'(a), 16'd0);
    wait_done();
    check_hdr_read(24'(a));
    chk(cs_n == 1'b0, "R3", "cs low while open", cs_n, 0);
    for (int k = 0; k < n; k++) begin
      do_cmd(3'd2, 24'd0, 16'd0);
      take_byte(fmem[(a + k) & 1023], int'($urandom_range(dmax)), "R4");
    end
    do_cmd(3'd3, 24'd0, 16'd0);
    wait_done();
    chk(cs_n == 1'b1 && cmd_ready, "R6", "close releases cs", {cs_n, cmd_ready}, 2'b11);
  endtask

  task automatic run_checked(input int a, input int n, input bit corrupt);
    logic [31:0] c;
    c = bench_crc(a, n);
    for (int t = 0; t < 4; t++) fmem[(a + n + t) & 1023] = c[8*t +: 8];
    if (corrupt) fmem[(a + n + 2) & 1023] ^= 8'h10;
    do_cmd(3'd6, 24'(a), 16'(n));
    for (int k = 0; k < n; k++) take_byte(fmem[(a + k) & 1023], int'($urandom_range(2)), "R9");
    wait_done();
    check_hdr_read(24'(a));
    chk(chk_pass == !corrupt, "R10", "crc verdict", chk_pass, !corrupt);
    chk(m_bytec == 4 + n + 4, "R9", "bytes in frame", m_bytec, 4 + n + 4);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && cmd_ready && !dout_valid && !op_done && !err, "R1", "reset outputs",
        {cs_n, sclk, cmd_ready, dout_valid, op_done, err}, 6'b101000);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL R12 watchdog expired: actual %0d expected <= %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int cf;
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) fmem[i] = 8'($urandom);
    for (int i = 0; i < 6; i++) m_hdr[i] = 8'h00;
    do_reset();

    // directed stream at address with all three bytes distinct
    run_stream(24'h000123, 3, 0);
    // random streams with back-pressure
    for (int it = 0; it < 5; it++)
      run_stream(int'($urandom_range(900)), int'($urandom_range(1, 6)), 3);

    // R7 status
    for (int it = 0; it < 2; it++) begin
      m_status = 8'($urandom);
      do_cmd(3'd4, 24'd0, 16'd0);
      wait_done();
      chk(status_q == m_status, "R7", "status byte", status_q, m_status);
      chk(m_hdr[0] == 8'h05 && m_hdr[1] == 8'h00 && m_bytec == 3, "R7", "status frame",
          {m_hdr[0], m_hdr[1], 8'(m_bytec)}, {8'h05, 8'h00, 8'd3});
      @(negedge clk);
      chk(cs_n == 1'b1, "R7", "cs released", cs_n, 1);
    end

    // R8 identifier
    m_id = 16'hBF41;
    for (int it = 0; it < 2; it++) begin
      do_cmd(3'd5, 24'd0, 16'd0);
      wait_done();
      chk(id_q == m_id, "R8", "identifier", id_q, m_id);
      chk({m_hdr[0], m_hdr[1], m_hdr[2], m_hdr[3]} == 32'h9000_0000 && m_bytec == 6, "R8",
          "identifier frame", {m_hdr[0], m_hdr[1], m_hdr[2], m_hdr[3]}, 32'h9000_0000);
      m_id = 16'($urandom);
    end

    // R9 R10 checked reads
    run_checked(40, 0, 1'b0);
    run_checked(100, 4, 1'b0);
    run_checked(300, 8, 1'b1);
    for (int it = 0; it < 3; it++)
      run_checked(int'($urandom_range(800)), 4 * int'($urandom_range(1, 4)), it[0]);

    chk(stray == 0, "R6", "sclk edges outside cs or cs rise at sclk high", stray, 0);
    chk(err == 1'b0, "R11", "no error after legal traffic", err, 0);

    // R11 illegal commands
    cf = cs_falls;
    do_cmd(3'd2, 24'd0, 16'd0);
    chk(err && cmd_ready && cs_falls == cf, "R11", "next in idle",
        {err, cmd_ready, 8'(cs_falls - cf)}, {1'b1, 1'b1, 8'd0});
    run_stream(24'h000050, 1, 0);
    chk(err == 1'b1, "R11", "error sticky", err, 1);

    do_reset();
    cf = cs_falls;
    do_cmd(3'd6, 24'd10, 16'd6);
    chk(err && cs_falls == cf, "R11", "checked length not multiple of 4",
        {err, 8'(cs_falls - cf)}, {1'b1, 8'd0});
    do_reset();
    cf = cs_falls;
    do_cmd(3'd7, 24'd0, 16'd0);
    chk(err && cs_falls == cf && cmd_ready, "R2", "reserved code rejected",
        {err, 8'(cs_falls - cf)}, {1'b1, 8'd0});

    do_reset();
    do_cmd(3'd1, 24'd200, 16'd0);
    wait_done();
    cf = cs_falls;
    do_cmd(3'd4, 24'd0, 16'd0);
    chk(err && cs_falls == cf && !cs_n && cmd_ready, "R11", "status while open",
        {err, cs_n, cmd_ready}, 3'b101);
    do_cmd(3'd2, 24'd0, 16'd0);
    take_byte(fmem[200], 1, "R4");
    do_cmd(3'd3, 24'd0, 16'd0);
    wait_done();
    chk(cs_n == 1'b1, "R6", "close after rejected command", cs_n, 1);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule